// File: doc/BRIEF.md
# Interrupt Vector Capture Register

This block sits beside a processor core and turns a device interrupt request into a vector dispatch. A device presents a level-sensitive request line together with a 6-bit request number. When a new request arrives and the block is idle, the block records it in three 64-bit data words. It then sets a busy flag, raises an interrupt line to the core, and sends the core a single-cycle pulse that releases it from halt.

While the busy flag is set, the block accepts no further request. A new request is either a rising request line, or a change of request number while the line stays high. The busy condition ends when the device drops its request line. Software inspects the captured words and the status register through a simple registered read port. Reading has no side effect.

Top module: `ivec_capture`

## Requirements
- R1: After a synchronous active-high reset, the busy flag is 0, the interrupt output is 0, the wake pulse is 0, and all three data words read as zero.
- R2: A new request means one of two events: `req_level` seen high after being low, or `req_num` changing while `req_level` stays high. If a new request arrives while busy is clear, the next clock edge sets busy and drives `irq_out` high.
- R3: On acceptance, data word 0 becomes the request number in bits 5:0 with bits 10:6 all ones (0x7C0 | number). All other bits of word 0 are zero, and words 1 and 2 become zero.
- R4: Each acceptance produces exactly one cycle of `wake_pulse` high, in the same cycle that `irq_out` first goes high.
- R5: A new request arriving while busy is set is ignored. Data word 0 keeps its value, busy and `irq_out` stay high, and no wake pulse is produced.
- R6: When `req_level` drops while busy is set, the next edge clears busy and `irq_out`. The data words keep their captured values.
- R7: When `req_level` drops while busy is clear, nothing changes. This case arises when the request was held high through reset. `irq_out`, busy and the data words remain as they were.
- R8: A read returns its value on `rd_data` one cycle after it is presented. With `rd_status` high the result is the status register: busy at bit 5, all other bits zero. Otherwise `rd_idx` values 0, 1 and 2 select the data words and value 3 returns zero. Reads never alter any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_level | input | 1 | Level-sensitive device request |
| req_num | input | 6 | Request number presented with the request |
| rd_status | input | 1 | Read select: status register when high |
| rd_idx | input | 2 | Data word index when `rd_status` is low |
| rd_data | output | 64 | Registered read result |
| irq_out | output | 1 | Interrupt line to the core |
| wake_pulse | output | 1 | One-cycle halt-release pulse |

## Verification
The hardest state to reach is a dropped request while the busy flag is already clear. In normal operation every high request line has set busy before it can fall. The bench reaches this state by holding `req_level` high through reset. Reset leaves busy clear without recording a rising edge, so the later drop hits an idle block and must leave the outputs and the zeroed words untouched.

A busy-time request is the second awkward case. The bench produces it by changing `req_num` while the line stays high.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int REQ_W    = 6;
  localparam int WORD_W   = 64;
  localparam int NWORDS   = 3;
  localparam int IDX_W    = 2;
  localparam int BUSY_BIT = 5;
  localparam int SRC_LSB  = 6;
  localparam int SRC_W    = 5;

  // Build the first data word: all-ones source field above the request number.
  function automatic logic [WORD_W-1:0] enc_word0(input logic [REQ_W-1:0] num);
    logic [WORD_W-1:0] w;
    w = '0;
    w[SRC_LSB +: SRC_W] = '1;
    w[REQ_W-1:0] = num;
    return w;
  endfunction
endpackage

// File: rtl/ivec_event.sv
module ivec_event #(
  parameter int REQ_W = ivec_pkg::REQ_W
) (
  input  logic             clk,
  input  logic             lvl,
  input  logic [REQ_W-1:0] num,
  output logic             ev_new,
  output logic             ev_drop
);
  logic             prev_lvl;
  logic [REQ_W-1:0] prev_num;

  // Tracks the inputs in every cycle, reset included, so that a request held
  // high through reset is not seen as a fresh edge afterwards.
  always_ff @(posedge clk) begin
    prev_lvl <= lvl;
    prev_num <= num;
  end

  always_comb begin
    ev_new  = lvl & (~prev_lvl | (num != prev_num));
    ev_drop = ~lvl & prev_lvl;
  end
endmodule

// File: rtl/ivec_state.sv
module ivec_state #(
  parameter int REQ_W  = ivec_pkg::REQ_W,
  parameter int WORD_W = ivec_pkg::WORD_W,
  parameter int NWORDS = ivec_pkg::NWORDS
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ev_new,
  input  logic                          ev_drop,
  input  logic [REQ_W-1:0]              num,
  output logic                          busy,
  output logic                          irq,
  output logic                          wake,
  output logic [NWORDS-1:0][WORD_W-1:0] words
);
  logic accept;
  logic release_q;

  always_comb begin
    accept    = ev_new & ~busy;
    release_q = ev_drop & busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      irq  <= 1'b0;
      wake <= 1'b0;
    end else begin
      wake <= accept;
      if (accept) begin
        busy <= 1'b1;
        irq  <= 1'b1;
      end else if (release_q) begin
        busy <= 1'b0;
        irq  <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words[g] <= '0;
      end else if (accept) begin
        if (g == 0) words[g] <= ivec_pkg::enc_word0(num);
        else        words[g] <= '0;
      end
    end
  end
endmodule

// File: rtl/ivec_rdport.sv
module ivec_rdport #(
  parameter int WORD_W   = ivec_pkg::WORD_W,
  parameter int NWORDS   = ivec_pkg::NWORDS,
  parameter int IDX_W    = ivec_pkg::IDX_W,
  parameter int BUSY_BIT = ivec_pkg::BUSY_BIT
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sel_status,
  input  logic [IDX_W-1:0]              idx,
  input  logic                          busy,
  input  logic [NWORDS-1:0][WORD_W-1:0] words,
  output logic [WORD_W-1:0]             data
);
  logic [WORD_W-1:0] status_w;
  logic [WORD_W-1:0] mux_w;

  always_comb begin
    status_w           = '0;
    status_w[BUSY_BIT] = busy;
    mux_w              = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (int'(idx) == i) mux_w = words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) data <= '0;
    else     data <= sel_status ? status_w : mux_w;
  end
endmodule

// File: rtl/ivec_capture.sv
module ivec_capture #(
  parameter int REQ_W    = ivec_pkg::REQ_W,
  parameter int WORD_W   = ivec_pkg::WORD_W,
  parameter int NWORDS   = ivec_pkg::NWORDS,
  parameter int IDX_W    = ivec_pkg::IDX_W,
  parameter int BUSY_BIT = ivec_pkg::BUSY_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_level,
  input  logic [REQ_W-1:0]  req_num,
  input  logic              rd_status,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_out,
  output logic              wake_pulse
);
  logic                          ev_new;
  logic                          ev_drop;
  logic                          busy;
  logic [NWORDS-1:0][WORD_W-1:0] words;
  logic [WORD_W-1:0]             word0;

  assign word0 = words[0];

  ivec_event #(.REQ_W(REQ_W)) u_event (
    .clk(clk), .lvl(req_level), .num(req_num),
    .ev_new(ev_new), .ev_drop(ev_drop)
  );

  ivec_state #(.REQ_W(REQ_W), .WORD_W(WORD_W), .NWORDS(NWORDS)) u_state (
    .clk(clk), .rst(rst), .ev_new(ev_new), .ev_drop(ev_drop), .num(req_num),
    .busy(busy), .irq(irq_out), .wake(wake_pulse), .words(words)
  );

  ivec_rdport #(.WORD_W(WORD_W), .NWORDS(NWORDS), .IDX_W(IDX_W),
                .BUSY_BIT(BUSY_BIT)) u_rd (
    .clk(clk), .rst(rst), .sel_status(rd_status), .idx(rd_idx),
    .busy(busy), .words(words), .data(rd_data)
  );
endmodule

// File: rtl/ivec_capture_chk.sv
module ivec_capture_chk #(
  parameter int REQ_W  = ivec_pkg::REQ_W,
  parameter int WORD_W = ivec_pkg::WORD_W
) (
  input logic              clk,
  input logic              rst,
  input logic              req_level,
  input logic [REQ_W-1:0]  req_num,
  input logic              irq_out,
  input logic              wake_pulse,
  input logic              busy,
  input logic [WORD_W-1:0] word0
);
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_level && !$past(req_level)) |=> irq_out);

  p_word_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_pulse) |-> (word0[10:6] == 5'h1f && word0[REQ_W-1:0] == $past(req_num)));

  p_single_wake_r4: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && req_level) |=> ($stable(word0) && !wake_pulse));

  p_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !req_level) |=> (!busy && !irq_out));

  p_idle_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req_level) |=> (!irq_out && $stable(word0)));
endmodule

bind ivec_capture ivec_capture_chk #(.REQ_W(REQ_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .req_level(req_level), .req_num(req_num),
  .irq_out(irq_out), .wake_pulse(wake_pulse), .busy(busy), .word0(word0)
);

// File: tb/tb_ivec_capture.sv
module tb_ivec_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_level = 1'b0;
  logic [5:0]  req_num = '0;
  logic        rd_status = 1'b0;
  logic [1:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic        irq_out;
  logic        wake_pulse;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ivec_capture dut (
    .clk(clk), .rst(rst), .req_level(req_level), .req_num(req_num),
    .rd_status(rd_status), .rd_idx(rd_idx), .rd_data(rd_data),
    .irq_out(irq_out), .wake_pulse(wake_pulse)
  );

  localparam int NV = 8;
  // Columns: level, number, expected irq, expected wake, expected busy, expected word 0
  localparam int V_LVL [NV] = '{1, 1, 1, 0, 0, 1, 0, 1};
  localparam int V_NUM [NV] = '{5, 5, 9, 9, 9, 63, 63, 0};
  localparam int V_IRQ [NV] = '{1, 1, 1, 0, 0, 1, 0, 1};
  localparam int V_WAK [NV] = '{1, 0, 0, 0, 0, 1, 0, 1};
  localparam int V_BSY [NV] = '{1, 1, 1, 0, 0, 1, 0, 1};
  localparam logic [63:0] V_W0 [NV] = '{64'h7c5, 64'h7c5, 64'h7c5, 64'h7c5,
                                        64'h7c5, 64'h7ff, 64'h7ff, 64'h7c0};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic st, input logic [1:0] idx, output logic [63:0] val);
    @(negedge clk);
    rd_status = st;
    rd_idx = idx;
    @(posedge clk);
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic drive(input logic lvl, input logic [5:0] num);
    @(negedge clk);
    req_level = lvl;
    req_num = num;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [63:0] v2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq", {63'b0, irq_out}, 64'd0);
    check("R1 wake", {63'b0, wake_pulse}, 64'd0);
    rd(1'b1, 2'd0, v); check("R1 status", v, 64'd0);
    for (int i = 0; i < 3; i++) begin
      rd(1'b0, 2'(i), v); check("R1 word", v, 64'd0);
    end

    // Table walk: R2 acceptance, R3 encoding, R4 wake, R5 busy ignore, R6 drop
    for (int k = 0; k < NV; k++) begin
      drive(V_LVL[k][0], 6'(V_NUM[k]));
      check("R2/R6 irq", {63'b0, irq_out}, 64'(V_IRQ[k]));
      check("R4 wake", {63'b0, wake_pulse}, 64'(V_WAK[k]));
      rd(1'b1, 2'd0, v); check("R8 status busy", v, 64'(V_BSY[k]) << 5);
      rd(1'b0, 2'd0, v); check("R3/R5 word0", v, V_W0[k]);
    end

    // R3: words 1 and 2 are zero after capture; R8: index 3 reads zero
    rd(1'b0, 2'd1, v); check("R3 word1", v, 64'd0);
    rd(1'b0, 2'd2, v); check("R3 word2", v, 64'd0);
    rd(1'b0, 2'd3, v); check("R8 idx3", v, 64'd0);
    // R8: repeated reads have no side effect
    rd(1'b0, 2'd0, v); rd(1'b0, 2'd0, v2);
    check("R8 repeat read", v2, v);
    check("R8 irq after reads", {63'b0, irq_out}, 64'd1);

    // R7: request held through reset, then dropped while busy is clear
    @(negedge clk);
    rst = 1'b1;
    req_level = 1'b1;
    req_num = 6'd17;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 irq after reset with req high", {63'b0, irq_out}, 64'd0);
    drive(1'b0, 6'd17);
    check("R7 irq after idle drop", {63'b0, irq_out}, 64'd0);
    check("R7 wake after idle drop", {63'b0, wake_pulse}, 64'd0);
    rd(1'b1, 2'd0, v); check("R7 status", v, 64'd0);
    rd(1'b0, 2'd0, v); check("R7 word0", v, 64'd0);

    // R2: a fresh rise after the idle drop is accepted
    drive(1'b1, 6'd42);
    check("R2 irq fresh rise", {63'b0, irq_out}, 64'd1);
    check("R4 wake fresh rise", {63'b0, wake_pulse}, 64'd1);
    @(negedge clk);
    check("R4 wake one cycle", {63'b0, wake_pulse}, 64'd0);
    rd(1'b0, 2'd0, v); check("R3 word0 42", v, 64'h7ea);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule